// File: doc/BRIEF.md
# Dual-Buffer Serial Memory Command Front-End

This block is a serial-peripheral target that presents the host-side command layer of a page-organised memory. Two on-chip page buffers and a small page array sit behind it. The host lowers chip select and shifts in an opcode, then address bytes. The block either fills a buffer, streams a buffer, an array page or the status byte back on the serial output, or starts a copy or compare between a buffer and an array page once chip select is released.

A static `pageBin` input sets the page length. A 256-byte page is binary. A 264-byte page is not, and in that case the byte field of the address is one bit wider. All serial pins are synchronised into the system clock domain, so SCK has to run well below the system clock. The output enable `soOe` stands for the tri-state control of the serial output pin.

Top module: `spiMemFront`

## Requirements
- R1: SCK may idle low (mode 0) or high (mode 3). SI is sampled on rising SCK, most significant bit first. Output bits change after falling SCK, most significant bit first, and `soOe` is high while a read streams data.
- R2: Raising csN ends any command. `soOe` falls within 3 clock cycles, and the next low period of csN starts with a new opcode.
- R3: The address is 24 bits, sent MSB first after the opcode. With pageBin=1 (256-byte pages), the page number is address bits [18:8] and the byte is bits [7:0]. With pageBin=0 (264-byte pages), the page number is bits [19:9] and the byte is bits [8:0].
- R4: Opcode 84h writes buffer 1 and 87h writes buffer 2. Every byte that follows the three address bytes is stored at the running byte address, which returns to 0 after the last byte of the page.
- R5: Opcode D1h reads buffer 1 and D3h reads buffer 2. Data starts right after the three address bytes, and the address wraps to 0 after the last byte of the page.
- R6: Opcode D2h reads an array page after three address bytes and four dummy bytes. After the last byte of the page it continues from byte 0 of the same page.
- R7: Opcode D7h streams the status byte repeatedly while csN stays low. The status byte is bit7 = 1 (ready), bit6 = compare flag, bits[5:2] = 0111, bit1 = 0, bit0 = pageBin. The values are 9Dh with 256-byte pages and a matching compare, DDh after a mismatch, and 9Ch with 264-byte pages.
- R8: Opcode 88h copies buffer 1 and 89h copies buffer 2 into the addressed array page. The copy starts when csN rises, and only if all three address bytes arrived. It finishes within 300 clock cycles.
- R9: Opcode 60h compares buffer 1 and 61h compares buffer 2 against the addressed page over the current page length, starting when csN rises. The compare flag becomes 0 if every byte matches and 1 otherwise.
- R10: Any other opcode is ignored. `soOe` stays low and no buffer changes until csN goes high.
- R11: After reset, `soOe` = 0, `so` = 0 and the compare flag = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCK |
| rstN | input | 1 | Asynchronous active-low reset |
| pageBin | input | 1 | 1 selects 256-byte pages, 0 selects 264-byte pages |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for the serial data pin |

## Verification
Buffer write-then-read pairs are run from a vector table. The table mixes both SCK idle levels, both buffers and several start addresses, so a swapped buffer select, a mode-dependent bit slip or a lost second byte each show up as a wrong byte. Directed cases start writes and reads next to the page end in both page lengths. A read at byte 263 that returns to byte 0 separates correct 264-byte wrapping from 256-byte wrapping. Copy, compare and aborted copy sequences are told apart by the array contents and by the compare flag seen in the status byte. An unknown opcode is checked by watching that `soOe` never rises and that buffer contents are unchanged afterwards.

// File: rtl/spiMemPkg.sv
package spiMemPkg;

  typedef enum logic [2:0] {
    K_NONE, K_RDBUF, K_RDPAGE, K_STATUS, K_WRBUF, K_PROG, K_CMP
  } cmdKind_e;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_IGN
  } phase_e;

  typedef enum logic [1:0] {
    SRC_BUF, SRC_PAGE, SRC_STATUS
  } txSrc_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       addrShift;
    logic       wrByte;
    logic       txLoad;
    logic       txShift;
    logic       startProg;
    logic       startCmp;
    logic       bufSel;
    txSrc_e     src;
    logic [7:0] rxByte;
  } dpCtl_t;

endpackage

// File: rtl/spiMemCtrl.sv
module spiMemCtrl
  import spiMemPkg::*;
#(
  parameter int DUMMY_BYTES = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sck,
  input  logic   csN,
  input  logic   si,
  output dpCtl_t ctl,
  output logic   soOe
);
  localparam int SYNC = 2;

  logic [SYNC-1:0] sckSync, csSync, siSync;
  logic sckPrev, csPrev;
  logic sckS, csHigh, siS, rise, fall, csRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      csSync  <= '1;
      siSync  <= '0;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckSync <= {sckSync[SYNC-2:0], sck};
      csSync  <= {csSync[SYNC-2:0], csN};
      siSync  <= {siSync[SYNC-2:0], si};
      sckPrev <= sckS;
      csPrev  <= csHigh;
    end
  end

  assign sckS   = sckSync[SYNC-1];
  assign csHigh = csSync[SYNC-1];
  assign siS    = siSync[SYNC-1];
  assign rise   = sckS & ~sckPrev;
  assign fall   = ~sckS & sckPrev;
  assign csRise = csHigh & ~csPrev;

  phase_e     phase;
  cmdKind_e   kind, decKind;
  logic       bufSel, decSel, soOeR;
  logic [2:0] bitCnt, byteCnt, outCnt;
  logic [6:0] shReg;
  logic [7:0] rxFull;
  logic       byteDone, isRead, txEdge;

  assign rxFull   = {shReg, siS};
  assign byteDone = rise & ~csHigh & (bitCnt == 3'd7);

  always_comb begin
    decSel = 1'b0;
    unique case (rxFull)
      8'hD1: decKind = K_RDBUF;
      8'hD3: begin decKind = K_RDBUF; decSel = 1'b1; end
      8'hD2: decKind = K_RDPAGE;
      8'hD7: decKind = K_STATUS;
      8'h84: decKind = K_WRBUF;
      8'h87: begin decKind = K_WRBUF; decSel = 1'b1; end
      8'h88: decKind = K_PROG;
      8'h89: begin decKind = K_PROG; decSel = 1'b1; end
      8'h60: decKind = K_CMP;
      8'h61: begin decKind = K_CMP; decSel = 1'b1; end
      default: decKind = K_NONE;
    endcase
  end

  assign isRead = (kind == K_RDBUF) | (kind == K_RDPAGE) | (kind == K_STATUS);
  assign txEdge = fall & ~csHigh & (phase == PH_DATA) & isRead;

  always_comb begin
    ctl.rxByte    = rxFull;
    ctl.addrShift = byteDone & (phase == PH_ADDR);
    ctl.wrByte    = byteDone & (phase == PH_DATA) & (kind == K_WRBUF);
    ctl.txLoad    = txEdge & (outCnt == 3'd0);
    ctl.txShift   = txEdge & (outCnt != 3'd0);
    ctl.startProg = csRise & (phase == PH_DATA) & (kind == K_PROG);
    ctl.startCmp  = csRise & (phase == PH_DATA) & (kind == K_CMP);
    ctl.bufSel    = bufSel;
    ctl.src       = (kind == K_STATUS) ? SRC_STATUS :
                    (kind == K_RDPAGE) ? SRC_PAGE : SRC_BUF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_OPC;
      kind    <= K_NONE;
      bufSel  <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
      outCnt  <= '0;
      shReg   <= '0;
      soOeR   <= 1'b0;
    end else if (csHigh) begin
      phase   <= PH_OPC;
      bitCnt  <= '0;
      byteCnt <= '0;
      outCnt  <= '0;
      soOeR   <= 1'b0;
    end else begin
      if (rise) begin
        shReg  <= {shReg[5:0], siS};
        bitCnt <= bitCnt + 3'd1;
      end
      if (byteDone) begin
        unique case (phase)
          PH_OPC: begin
            kind    <= decKind;
            bufSel  <= decSel;
            byteCnt <= '0;
            phase   <= (decKind == K_STATUS) ? PH_DATA :
                       (decKind == K_NONE)   ? PH_IGN  : PH_ADDR;
          end
          PH_ADDR: begin
            byteCnt <= byteCnt + 3'd1;
            if (byteCnt == 3'd2) begin
              byteCnt <= '0;
              phase   <= (kind == K_RDPAGE && DUMMY_BYTES != 0) ? PH_DUMMY : PH_DATA;
            end
          end
          PH_DUMMY: begin
            byteCnt <= byteCnt + 3'd1;
            if (byteCnt == 3'(DUMMY_BYTES - 1)) phase <= PH_DATA;
          end
          default: ;
        endcase
      end
      if (txEdge) begin
        outCnt <= outCnt + 3'd1;
        soOeR  <= 1'b1;
      end
    end
  end

  assign soOe = soOeR;

endmodule

// File: rtl/spiMemDp.sv
module spiMemDp
  import spiMemPkg::*;
#(
  parameter int         PAGE_MAX    = 264,
  parameter int         ARRAY_PAGES = 8,
  parameter logic [3:0] DENSITY     = 4'b0111
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pageBin,
  input  dpCtl_t ctl,
  output logic   so
);
  localparam int BIN_PAGE  = 256;
  localparam int PTR_W     = $clog2(PAGE_MAX);
  localparam int PG_W      = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1;
  localparam int ARR_DEPTH = ARRAY_PAGES * PAGE_MAX;
  localparam int ARR_W     = $clog2(ARR_DEPTH);
  localparam int ADDR_W    = 20;

  logic [7:0] bufMem [2][PAGE_MAX];
  logic [7:0] arrMem [ARR_DEPTH];

  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [PTR_W-1:0]  ptr, ptrNext, lastByte, startByte, engCnt;
  logic [10:0]       pageField;
  logic [PG_W-1:0]   pageIdx, engPage;
  logic [ARR_W-1:0]  rdIdx, engIdx;
  logic [7:0]        txByte;
  logic [6:0]        txSh;
  logic              ptrOk, cmpFlag, engOn, engCmp, engSel, engDiff, curDiff;

  assign addrNext  = {addrReg[ADDR_W-9:0], ctl.rxByte};
  assign startByte = pageBin ? PTR_W'(addrNext[7:0]) : PTR_W'(addrNext[8:0]);
  assign pageField = pageBin ? addrReg[18:8] : addrReg[19:9];
  assign pageIdx   = PG_W'(pageField % ARRAY_PAGES);
  assign lastByte  = pageBin ? PTR_W'(BIN_PAGE - 1) : PTR_W'(PAGE_MAX - 1);
  assign ptrNext   = (ptr >= lastByte) ? '0 : ptr + 1'b1;
  assign ptrOk     = (int'(ptr) < PAGE_MAX);
  assign rdIdx     = ARR_W'(pageIdx) * ARR_W'(PAGE_MAX) + ARR_W'(ptr);
  assign engIdx    = ARR_W'(engPage) * ARR_W'(PAGE_MAX) + ARR_W'(engCnt);
  assign curDiff   = bufMem[engSel][engCnt] != arrMem[engIdx];

  always_comb begin
    unique case (ctl.src)
      SRC_BUF:    txByte = ptrOk ? bufMem[ctl.bufSel][ptr] : 8'h00;
      SRC_PAGE:   txByte = ptrOk ? arrMem[rdIdx] : 8'h00;
      default:    txByte = {1'b1, cmpFlag, DENSITY, 1'b0, pageBin};
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.wrByte && ptrOk) bufMem[ctl.bufSel][ptr] <= ctl.rxByte;
    if (engOn && !engCmp) arrMem[engIdx] <= bufMem[engSel][engCnt];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      ptr     <= '0;
      so      <= 1'b0;
      txSh    <= '0;
      cmpFlag <= 1'b0;
      engOn   <= 1'b0;
      engCmp  <= 1'b0;
      engSel  <= 1'b0;
      engPage <= '0;
      engCnt  <= '0;
      engDiff <= 1'b0;
    end else begin
      if (ctl.addrShift) begin
        addrReg <= addrNext;
        ptr     <= startByte;
      end
      if (ctl.wrByte) ptr <= ptrNext;
      if (ctl.txLoad) begin
        so   <= txByte[7];
        txSh <= txByte[6:0];
        if (ctl.src != SRC_STATUS) ptr <= ptrNext;
      end
      if (ctl.txShift) begin
        so   <= txSh[6];
        txSh <= {txSh[5:0], 1'b0};
      end
      if (ctl.startProg || ctl.startCmp) begin
        engOn   <= 1'b1;
        engCmp  <= ctl.startCmp;
        engSel  <= ctl.bufSel;
        engPage <= pageIdx;
        engCnt  <= '0;
        engDiff <= 1'b0;
      end else if (engOn) begin
        if (engCmp && curDiff) engDiff <= 1'b1;
        engCnt <= engCnt + 1'b1;
        if (engCnt == lastByte) begin
          engOn <= 1'b0;
          if (engCmp) cmpFlag <= engDiff | curDiff;
        end
      end
    end
  end

endmodule

// File: rtl/spiMemFront.sv
module spiMemFront
  import spiMemPkg::*;
#(
  parameter int         PAGE_MAX    = 264,
  parameter int         ARRAY_PAGES = 8,
  parameter int         DUMMY_BYTES = 4,
  parameter logic [3:0] DENSITY     = 4'b0111
) (
  input  logic clk,
  input  logic rstN,
  input  logic pageBin,
  input  logic sck,
  input  logic csN,
  input  logic si,
  output logic so,
  output logic soOe
);
  dpCtl_t ctl;

  spiMemCtrl #(.DUMMY_BYTES(DUMMY_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si),
    .ctl(ctl), .soOe(soOe)
  );

  spiMemDp #(.PAGE_MAX(PAGE_MAX), .ARRAY_PAGES(ARRAY_PAGES), .DENSITY(DENSITY)) u_dp (
    .clk(clk), .rstN(rstN), .pageBin(pageBin), .ctl(ctl), .so(so)
  );

endmodule

// File: rtl/spiMemFront_chk.sv
module spiMemFront_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic soOe,
  input logic addrShift,
  input logic wrByte,
  input logic txLoad,
  input logic txShift,
  input logic startProg,
  input logic startCmp
);
  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> ##3 !soOe);

  // R1
  tx_cs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad || txShift) |-> !$past(csN, 2));

  // R8
  start_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startProg || startCmp) |-> ($past(csN, 2) && !$past(csN, 3)));

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrByte |-> !soOe);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrShift, wrByte, txLoad, startProg, startCmp}));

endmodule

bind spiMemFront spiMemFront_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .soOe(soOe),
  .addrShift(ctl.addrShift), .wrByte(ctl.wrByte), .txLoad(ctl.txLoad),
  .txShift(ctl.txShift), .startProg(ctl.startProg), .startCmp(ctl.startCmp)
);

// File: tb/spiMemFront_bench.sv
module spiMemFront_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN, pageBin, sck, csN, si;
  logic so, soOe;

  always #4 clk = ~clk;

  spiMemFront u_spiMemFront (
    .clk(clk), .rstN(rstN), .pageBin(pageBin), .sck(sck), .csN(csN),
    .si(si), .so(so), .soOe(soOe)
  );

  int   checks = 0;
  int   errors = 0;
  logic done = 1'b0;
  logic modeHi = 1'b0;
  logic [7:0] wrData [300];
  logic [7:0] rdData [16];
  logic       rdOeAll;

  // {modeHi, buffer, byte address, first data byte}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h00, 8'h11},
    {1'b1, 1'b1, 8'h10, 8'hA5},
    {1'b0, 1'b1, 8'hFE, 8'h3C},
    {1'b1, 1'b0, 8'h7F, 8'h80},
    {1'b0, 1'b0, 8'h40, 8'hFF},
    {1'b1, 1'b1, 8'h00, 8'h01}
  };

  function automatic logic [7:0] fillVal(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
    oe = 1'b1;
    rx = '0;
    for (int b = 7; b >= 0; b--) begin
      sck = 1'b0;
      si  = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = so;
      oe    = oe & soOe;
      sck   = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] addr, input int nAddr,
                     input int nDummy, input int nData, input bit isWr);
    logic [7:0] r;
    logic o;
    sck = modeHi;
    repeat (2) @(negedge clk);
    csN = 1'b0;
    repeat (H) @(negedge clk);
    xfer(op, r, o);
    for (int i = 0; i < nAddr; i++) xfer(addr[23 - 8*i -: 8], r, o);
    for (int i = 0; i < nDummy; i++) xfer(8'h00, r, o);
    rdOeAll = 1'b1;
    for (int i = 0; i < nData; i++) begin
      xfer(isWr ? wrData[i] : 8'h00, r, o);
      if (i < 16) rdData[i] = r;
      rdOeAll = rdOeAll & o;
    end
    if (!modeHi) begin
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pageBin = 1'b1; sck = 1'b0; csN = 1'b1; si = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 soOe after reset", {7'b0, soOe}, 8'h00);
    check("R11 so after reset", {7'b0, so}, 8'h00);

    // R7 status streamed twice, compare flag clear after reset
    run(8'hD7, 24'h0, 0, 0, 2, 1'b0);
    check("R7 status byte 0", rdData[0], 8'h9D);
    check("R7 status byte 1", rdData[1], 8'h9D);
    check("R1 soOe during read", {7'b0, rdOeAll}, 8'h01);
    check("R2 soOe after csN high", {7'b0, soOe}, 8'h00);

    // R4 R5 table of buffer write/read pairs in both SCK modes
    for (int v = 0; v < 6; v++) begin
      modeHi    = VEC[v][17];
      wrData[0] = VEC[v][7:0];
      wrData[1] = ~VEC[v][7:0];
      run(VEC[v][16] ? 8'h87 : 8'h84, {16'h0, VEC[v][15:8]}, 3, 0, 2, 1'b1);
      run(VEC[v][16] ? 8'hD3 : 8'hD1, {16'h0, VEC[v][15:8]}, 3, 0, 2, 1'b0);
      check("R4 R5 table byte 0", rdData[0], VEC[v][7:0]);
      check("R4 R5 table byte 1", rdData[1], ~VEC[v][7:0]);
    end

    // R4 R5 wrap at 256-byte page end
    modeHi = 1'b0;
    wrData[0] = 8'h21; wrData[1] = 8'h22; wrData[2] = 8'h23;
    run(8'h84, 24'h0000FE, 3, 0, 3, 1'b1);
    run(8'hD1, 24'h000000, 3, 0, 1, 1'b0);
    check("R4 write wraps to byte 0", rdData[0], 8'h23);
    run(8'hD1, 24'h0000FF, 3, 0, 2, 1'b0);
    check("R5 read last byte", rdData[0], 8'h22);
    check("R5 read wraps to byte 0", rdData[1], 8'h23);

    // R3 264-byte pages: byte field is 9 bits, wrap after byte 263
    pageBin = 1'b0;
    modeHi = 1'b1;
    wrData[0] = 8'h31; wrData[1] = 8'h32; wrData[2] = 8'h33;
    run(8'h87, 24'h000106, 3, 0, 3, 1'b1);
    run(8'hD3, 24'h000107, 3, 0, 2, 1'b0);
    check("R3 byte 263", rdData[0], 8'h32);
    check("R3 wrap after 263", rdData[1], 8'h33);
    run(8'hD3, 24'h000106, 3, 0, 1, 1'b0);
    check("R3 byte 262", rdData[0], 8'h31);
    run(8'hD7, 24'h0, 0, 0, 1, 1'b0);
    check("R7 status in 264 mode", rdData[0], 8'h9C);
    pageBin = 1'b1;

    // R8 R6 copy buffer 1 to page 2, read it back across the wrap
    modeHi = 1'b0;
    for (int i = 0; i < 256; i++) wrData[i] = fillVal(i);
    run(8'h84, 24'h000000, 3, 0, 256, 1'b1);
    run(8'h88, 24'h000200, 3, 0, 0, 1'b1);
    repeat (300) @(negedge clk);
    modeHi = 1'b1;
    run(8'hD2, 24'h0002FE, 3, 4, 3, 1'b0);
    check("R6 page byte 254", rdData[0], fillVal(254));
    check("R6 page byte 255", rdData[1], fillVal(255));
    check("R6 page wraps to byte 0", rdData[2], fillVal(0));

    // R9 compare mismatch then match
    modeHi = 1'b0;
    wrData[0] = ~fillVal(16);
    run(8'h84, 24'h000010, 3, 0, 1, 1'b1);
    run(8'h60, 24'h000200, 3, 0, 0, 1'b1);
    repeat (300) @(negedge clk);
    run(8'hD7, 24'h0, 0, 0, 1, 1'b0);
    check("R9 mismatch sets bit6", rdData[0], 8'hDD);
    wrData[0] = fillVal(16);
    run(8'h84, 24'h000010, 3, 0, 1, 1'b1);
    run(8'h60, 24'h000200, 3, 0, 0, 1'b1);
    repeat (300) @(negedge clk);
    run(8'hD7, 24'h0, 0, 0, 1, 1'b0);
    check("R9 match clears bit6", rdData[0], 8'h9D);

    // R8 copy aborted after one address byte leaves page unchanged
    wrData[0] = 8'hC3;
    run(8'h84, 24'h000005, 3, 0, 1, 1'b1);
    run(8'h88, 24'h000200, 1, 0, 0, 1'b1);
    repeat (300) @(negedge clk);
    run(8'hD2, 24'h000205, 3, 4, 1, 1'b0);
    check("R8 aborted copy no effect", rdData[0], fillVal(5));

    // R10 unknown opcode: no output drive, no buffer change
    modeHi = 1'b1;
    run(8'h42, 24'h0, 0, 0, 4, 1'b0);
    check("R10 soOe stays low", {7'b0, rdOeAll}, 8'h00);
    run(8'hD1, 24'h000010, 3, 0, 1, 1'b0);
    check("R10 buffer unchanged", rdData[0], fillVal(16));
    run(8'hD7, 24'h0, 0, 0, 1, 1'b0);
    check("R2 R7 next command after unknown", rdData[0], 8'h9D);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule